// File: doc/BRIEF.md
# Serial Flash Slave Command Front-End

This block is the serial slave side of a small flash memory model. It watches chip-select, serial clock and serial data in, all sampled by a faster system clock with edge detection. It collects the opcode byte and a 24-bit address MSB-first, and then does one of three things. It streams array bytes from an external synchronous read port with address auto-increment. It streams the status byte or the identification sequence. Or it hands write-type commands to a separate write controller as decoded one-cycle pulses. Erase and program timing, WEN storage and the array itself live outside this block.

The serial host cannot be stalled, so both outgoing streams (program data bytes and command pulses) are valid-only. They have no ready and no back-pressure, and the receiver must accept each pulse in the cycle it appears. The read port has a fixed latency: data is taken on `mem_rd_data` one system clock after `mem_rd_en`. Output data always changes on a falling SCK edge and input is always taken on a rising SCK edge. The clock may therefore idle low or high when chip-select falls. The SCK half period must be at least eight system clocks.

Top module: `flash_spi_frontend`

## Requirements
- R1: After reset, and whenever chip-select is high, `spi_miso_oe` is 0. It is also 0 while opcode, address or dummy bits are being received.
- R2: Opcode 0x03 followed by three address bytes makes the block stream, MSB-first, the bytes at that address and each next address. The first bit is driven on the falling edge after the last address bit. Address bits 23 to 19 are ignored, which leaves a 19-bit space.
- R3: Opcode 0x0B behaves like 0x03, but one extra dummy byte follows the address before data starts.
- R4: Read addresses wrap from 0x7FFFF to 0x00000, and output continues without a break.
- R5: Opcode 0x05 streams the status byte {6'b0, wen, busy} repeatedly, MSB-first, for as long as the clock runs. This also holds while busy is 1.
- R6: Opcode 0x9F streams 0x62, 0x11, 0x00 and then repeats. While `wr_busy` is 1 at the end of the opcode, the command is ignored and the output stays high-impedance.
- R7: Input bits are taken on rising SCK and output bits change on falling SCK. Reads work alike whether SCK idles low or high at chip-select fall.
- R8: A recognised write-type command gives one `cmd_valid` pulse after chip-select rises. `cmd_kind` is coded as: 0 write enable (0x06), 1 write disable (0x04), 2 page erase (0xDB), 3 sector erase (0xD8), 4 chip erase (0xC7), 5 page program (0x02), 6 page write (0x0A). `cmd_addr` carries the low 19 address bits.
- R9: During 0x02 or 0x0A, each complete data byte after the address gives one `wbyte_valid` pulse with the byte on `wbyte_data`. The pulse never coincides with `cmd_valid`.
- R10: No command pulse is given if chip-select rises off a byte boundary. None is given for an erase with fewer than four bytes, or for a program with no complete data byte.
- R11: After 0xB9, every opcode except 0xAB is ignored: there is no output and no command pulse. 0xAB restores normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data-out pad; 0 means high-impedance |
| mem_rd_en | output | 1 | Read strobe to the array port |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array data, valid one cycle after the strobe |
| wr_busy | input | 1 | Write controller busy flag |
| wr_enabled | input | 1 | Write enable flag kept by the write controller |
| cmd_valid | output | 1 | One-cycle pulse for a recognised write-type command |
| cmd_kind | output | 3 | Command code, as listed in R8 |
| cmd_addr | output | ADDR_W | Address of the command |
| wbyte_valid | output | 1 | One-cycle pulse per program data byte |
| wbyte_data | output | 8 | Program data byte |

## Verification
Reads are run with a normal start address whose top address bits are set, with a fast read in the other clock idle level, and with a start just below the top address. Together these tell a correct address mask, the dummy-byte offset, clock-mode handling and wrap-around apart from a plain incrementer. Status and ID reads run for more bytes than one period, so a stream that stops or restarts wrongly shows up, and the ID read is repeated with busy set. Write commands are sent both whole and cut short (stray trailing bits, a truncated erase), and again inside power-down. This separates byte-boundary qualification and power-down gating from simple opcode decoding.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_FREAD  = 8'h0B;
  localparam logic [7:0] OP_PERASE = 8'hDB;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_CERASE = 8'hC7;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_PWRITE = 8'h0A;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_PDOWN  = 8'hB9;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_IDENT  = 8'h9F;
  localparam logic [7:0] OP_PDEXIT = 8'hAB;

  localparam logic [2:0] K_WREN   = 3'd0;
  localparam logic [2:0] K_WRDI   = 3'd1;
  localparam logic [2:0] K_PERASE = 3'd2;
  localparam logic [2:0] K_SERASE = 3'd3;
  localparam logic [2:0] K_CERASE = 3'd4;
  localparam logic [2:0] K_PROG   = 3'd5;
  localparam logic [2:0] K_PWRITE = 3'd6;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_IDENT} src_e;
endpackage

// File: rtl/fe_pin_sync.sv
module fe_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic mosi_s
);
  logic [STAGES-1:0] cs_p, sck_p, mo_p;
  logic cs_q, sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '0;
      mo_p  <= '0;
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_p  <= {cs_p[STAGES-2:0], cs_n_i};
      sck_p <= {sck_p[STAGES-2:0], sck_i};
      mo_p  <= {mo_p[STAGES-2:0], mosi_i};
      cs_q  <= cs_p[STAGES-1];
      sck_q <= sck_p[STAGES-1];
    end
  end

  assign sel      = ~cs_p[STAGES-1];
  assign mosi_s   = mo_p[STAGES-1];
  assign sck_rise = sel & sck_p[STAGES-1] & ~sck_q;
  assign sck_fall = sel & ~sck_p[STAGES-1] & sck_q;
  assign cs_rise  = cs_p[STAGES-1] & ~cs_q;
endmodule

// File: rtl/fe_cmd_parser.sv
module fe_cmd_parser
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              cs_rise,
  input  logic              mosi,
  input  logic              busy,
  output logic              tx_start,
  output src_e              tx_src,
  output logic [ADDR_W-1:0] tx_addr,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wbyte_valid,
  output logic [7:0]        wbyte_data
);
  logic [2:0] bitcnt, bytecnt;
  logic [6:0] sh;
  logic [7:0] op;
  logic [ADDR_W-1:0] addr;
  logic ignore_q, pd_q;
  logic [7:0] rx_byte;
  logic byte_done;
  logic [ADDR_W+7:0] addr_cat;
  logic is_wdata;

  assign rx_byte   = {sh, mosi};
  assign byte_done = sck_rise && (bitcnt == 3'd7);
  assign addr_cat  = {addr, rx_byte};
  assign is_wdata  = (op == OP_PROG) || (op == OP_PWRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0; bytecnt <= '0; sh <= '0; op <= '0; addr <= '0;
      ignore_q <= 1'b0; pd_q <= 1'b0;
      tx_start <= 1'b0; tx_src <= SRC_ARRAY; tx_addr <= '0;
      cmd_valid <= 1'b0; cmd_kind <= '0; cmd_addr <= '0;
      wbyte_valid <= 1'b0; wbyte_data <= '0;
    end else begin
      tx_start    <= 1'b0;
      cmd_valid   <= 1'b0;
      wbyte_valid <= 1'b0;
      // commit on deselect, only on a whole number of bytes
      if (cs_rise && !ignore_q && bitcnt == 3'd0 && bytecnt != 3'd0) begin
        cmd_addr <= addr;
        case (op)
          OP_WREN:   begin cmd_valid <= 1'b1; cmd_kind <= K_WREN; end
          OP_WRDI:   begin cmd_valid <= 1'b1; cmd_kind <= K_WRDI; end
          OP_CERASE: begin cmd_valid <= 1'b1; cmd_kind <= K_CERASE; end
          OP_PERASE: if (bytecnt >= 3'd4) begin cmd_valid <= 1'b1; cmd_kind <= K_PERASE; end
          OP_SERASE: if (bytecnt >= 3'd4) begin cmd_valid <= 1'b1; cmd_kind <= K_SERASE; end
          OP_PROG:   if (bytecnt >= 3'd5) begin cmd_valid <= 1'b1; cmd_kind <= K_PROG; end
          OP_PWRITE: if (bytecnt >= 3'd5) begin cmd_valid <= 1'b1; cmd_kind <= K_PWRITE; end
          OP_PDOWN:  pd_q <= 1'b1;
          OP_PDEXIT: pd_q <= 1'b0;
          default: ;
        endcase
      end
      if (!sel) begin
        bitcnt <= '0; bytecnt <= '0; ignore_q <= 1'b0;
      end else if (sck_rise) begin
        sh     <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (byte_done) begin
          if (bytecnt != 3'd7) bytecnt <= bytecnt + 3'd1;
          case (bytecnt)
            3'd0: begin
              op <= rx_byte;
              if (pd_q && rx_byte != OP_PDEXIT) ignore_q <= 1'b1;
              else if (rx_byte == OP_STATUS) begin
                tx_start <= 1'b1; tx_src <= SRC_STATUS;
              end else if (rx_byte == OP_IDENT) begin
                if (busy) ignore_q <= 1'b1;
                else begin tx_start <= 1'b1; tx_src <= SRC_IDENT; end
              end
            end
            3'd1, 3'd2: addr <= addr_cat[ADDR_W-1:0];
            3'd3: begin
              addr <= addr_cat[ADDR_W-1:0];
              if (op == OP_READ && !ignore_q) begin
                tx_start <= 1'b1; tx_src <= SRC_ARRAY; tx_addr <= addr_cat[ADDR_W-1:0];
              end
            end
            default: begin
              if (bytecnt == 3'd4 && op == OP_FREAD && !ignore_q) begin
                tx_start <= 1'b1; tx_src <= SRC_ARRAY; tx_addr <= addr;
              end
              if (is_wdata && !ignore_q) begin
                wbyte_valid <= 1'b1; wbyte_data <= rx_byte;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fe_tx_engine.sv
module fe_tx_engine
  import flash_fe_pkg::*;
#(
  parameter int         ADDR_W = 19,
  parameter logic [7:0] ID0    = 8'h62,
  parameter logic [7:0] ID1    = 8'h11,
  parameter logic [7:0] ID2    = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sck_fall,
  input  logic              start,
  input  src_e              src,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              busy,
  input  logic              wen,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              miso,
  output logic              miso_oe
);
  logic act, mem_wait;
  logic [7:0] cur, nb, stat;
  logic [2:0] bitpos;
  logic [1:0] idx;
  logic [ADDR_W-1:0] rd_addr;
  src_e src_q;

  assign stat = {6'b0, wen, busy};
  assign miso = cur[7];

  function automatic logic [7:0] id_byte(input logic [1:0] i);
    case (i)
      2'd0:    return ID0;
      2'd1:    return ID1;
      default: return ID2;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; miso_oe <= 1'b0; mem_wait <= 1'b0; mem_rd_en <= 1'b0;
      mem_rd_addr <= '0; rd_addr <= '0; cur <= '0; nb <= '0;
      bitpos <= '0; idx <= '0; src_q <= SRC_ARRAY;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wait  <= mem_rd_en;
      if (mem_wait) nb <= mem_rd_data;
      if (!sel) begin
        act <= 1'b0; miso_oe <= 1'b0;
      end else if (start) begin
        act <= 1'b1; src_q <= src; bitpos <= '0;
        case (src)
          SRC_ARRAY: begin
            mem_rd_en <= 1'b1; mem_rd_addr <= start_addr; rd_addr <= start_addr + 1'b1;
          end
          SRC_STATUS: nb <= stat;
          default: begin nb <= ID0; idx <= 2'd1; end
        endcase
      end else if (sck_fall && act) begin
        bitpos <= bitpos + 3'd1;
        if (bitpos == 3'd0) begin
          cur <= nb; miso_oe <= 1'b1;
          case (src_q)
            SRC_ARRAY: begin
              mem_rd_en <= 1'b1; mem_rd_addr <= rd_addr; rd_addr <= rd_addr + 1'b1;
            end
            SRC_STATUS: nb <= stat;
            default: begin
              nb  <= id_byte(idx);
              idx <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
            end
          endcase
        end else begin
          cur <= {cur[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/flash_spi_frontend.sv
module flash_spi_frontend
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic              wr_busy,
  input  logic              wr_enabled,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wbyte_valid,
  output logic [7:0]        wbyte_data
);
  logic sel, sck_rise, sck_fall, cs_rise, mosi_s, tx_start;
  src_e tx_src;
  logic [ADDR_W-1:0] tx_addr;

  fe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise), .mosi_s(mosi_s));

  fe_cmd_parser #(.ADDR_W(ADDR_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise), .cs_rise(cs_rise),
    .mosi(mosi_s), .busy(wr_busy), .tx_start(tx_start), .tx_src(tx_src), .tx_addr(tx_addr),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .wbyte_valid(wbyte_valid), .wbyte_data(wbyte_data));

  fe_tx_engine #(.ADDR_W(ADDR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_fall(sck_fall), .start(tx_start),
    .src(tx_src), .start_addr(tx_addr), .busy(wr_busy), .wen(wr_enabled),
    .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .miso(spi_miso), .miso_oe(spi_miso_oe));
endmodule

// File: rtl/flash_spi_frontend_chk.sv
module flash_spi_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso_oe,
  input logic       mem_rd_en,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       wbyte_valid
);
  // R1
  deselect_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);
  // R1
  oe_rise_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_oe) |-> !spi_cs_n);
  // R2
  rd_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  // R8
  cmd_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> spi_cs_n);
  // R8
  cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R8
  cmd_kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind <= 3'd6));
  // R9
  wbyte_cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wbyte_valid));
  // R9
  wbyte_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_valid |=> !wbyte_valid);
endmodule

bind flash_spi_frontend flash_spi_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .mem_rd_en(mem_rd_en), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .wbyte_valid(wbyte_valid));

// File: tb/flash_spi_frontend_tb.sv
module flash_spi_frontend_tb;
  localparam int HP = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic busy = 1'b0, wen = 1'b0;
  logic miso, miso_oe, mem_rd_en, cmd_valid, wbyte_valid;
  logic [18:0] mem_rd_addr, cmd_addr;
  logic [7:0] mem_rd_data = 8'h00, wbyte_data;
  logic [2:0] cmd_kind;
  int total = 0, fails = 0, cmd_seen = 0;
  logic [7:0]  rx_q[$];
  logic [21:0] cmd_q[$];
  logic [7:0]  wb_q[$];

  always #5 clk = ~clk;

  flash_spi_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .wr_busy(busy),
    .wr_enabled(wen), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .wbyte_valid(wbyte_valid), .wbyte_data(wbyte_data));

  function automatic logic [7:0] memf(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'h15};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: command and data-byte pulses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      cmd_seen++;
      if (cmd_q.size() == 0) check(1'b0, "R10 unexpected command", {10'd0, cmd_kind, cmd_addr}, 32'h0);
      else begin
        logic [21:0] e;
        e = cmd_q.pop_front();
        check({cmd_kind, cmd_addr} == e, "R8 command", {10'd0, cmd_kind, cmd_addr}, {10'd0, e});
      end
    end
    if (rst_n && wbyte_valid) begin
      if (wb_q.size() == 0) check(1'b0, "R9 unexpected data byte", {24'd0, wbyte_data}, 32'h0);
      else begin
        logic [7:0] w;
        w = wb_q.pop_front();
        check(wbyte_data == w, "R9 data byte", {24'd0, wbyte_data}, {24'd0, w});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_start(input bit m3);
    sck = m3; tick(2); cs_n = 1'b0; tick(HP);
  endtask

  task automatic spi_end(input bit m3);
    if (!m3) begin sck = 1'b0; tick(HP); end
    cs_n = 1'b1; tick(3 * HP);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx, output logic oe_seen);
    rx = 8'h00; oe_seen = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0; mosi = tx[i]; tick(HP);
      rx[i] = miso; oe_seen = oe_seen | miso_oe;
      sck = 1'b1; tick(HP);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; logic o;
    spi_bits(tx, 8, r, o);
  endtask

  task automatic read_check(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] r, e; logic o;
      spi_bits(8'h00, 8, r, o);
      e = rx_q.pop_front();
      check(o && r == e, tag, {23'd0, o, r}, {23'd1, e});
    end
  endtask

  task automatic quiet_check(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] r; logic o;
      spi_bits(8'h00, 8, r, o);
      check(!o, tag, {31'd0, o}, 32'd0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #2000000;
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int c0;
    tick(5);
    check(miso_oe == 1'b0, "R1 reset output enable", {31'd0, miso_oe}, 32'd0);
    rst_n = 1'b1; tick(5);
    check(miso_oe == 1'b0, "R1 idle output enable", {31'd0, miso_oe}, 32'd0);

    // R2: read with top address bits set, mode 0
    for (int k = 0; k < 4; k++) rx_q.push_back(memf(19'h01234 + 19'(k)));
    spi_start(0); send(8'h03); send(8'hF8); send(8'h12); send(8'h34);
    read_check("R2 read data", 4); spi_end(0);

    // R3 R7: fast read, clock idling high
    for (int k = 0; k < 3; k++) rx_q.push_back(memf(19'h00100 + 19'(k)));
    spi_start(1); send(8'h0B); send(8'h00); send(8'h01); send(8'h00);
    begin
      logic [7:0] r; logic o;
      spi_bits(8'hFF, 8, r, o);
      check(!o, "R3 dummy byte tristate", {31'd0, o}, 32'd0);
    end
    read_check("R3 R7 fast read mode 3", 3); spi_end(1);

    // R4: wrap at the top
    rx_q.push_back(memf(19'h7FFFE)); rx_q.push_back(memf(19'h7FFFF));
    rx_q.push_back(memf(19'h00000)); rx_q.push_back(memf(19'h00001));
    spi_start(0); send(8'h03); send(8'h07); send(8'hFF); send(8'hFE);
    read_check("R4 wrap read", 4); spi_end(0);

    // R5: status stream idle then busy
    wen = 1'b1; busy = 1'b0;
    repeat (3) rx_q.push_back(8'h02);
    spi_start(0); send(8'h05); read_check("R5 status idle", 3); spi_end(0);
    busy = 1'b1;
    repeat (3) rx_q.push_back(8'h03);
    spi_start(1); send(8'h05); read_check("R5 status busy", 3); spi_end(1);

    // R6: ID refused while busy, then streamed
    spi_start(0); send(8'h9F); quiet_check("R6 ID while busy", 2); spi_end(0);
    busy = 1'b0;
    rx_q.push_back(8'h62); rx_q.push_back(8'h11); rx_q.push_back(8'h00);
    rx_q.push_back(8'h62); rx_q.push_back(8'h11);
    spi_start(1); send(8'h9F); read_check("R6 ID stream", 5); spi_end(1);

    // R8: single-byte and addressed commands
    cmd_q.push_back({3'd0, 19'h00000}); spi_start(0); send(8'h06); spi_end(0);
    cmd_q.push_back({3'd3, 19'h25500});
    spi_start(0); send(8'hD8); send(8'h0A); send(8'h55); send(8'h00); spi_end(0);
    cmd_q.push_back({3'd4, 19'h25500}); spi_start(1); send(8'hC7); spi_end(1);
    cmd_q.push_back({3'd1, 19'h25500}); spi_start(0); send(8'h04); spi_end(0);
    cmd_q.push_back({3'd2, 19'h00A00});
    spi_start(1); send(8'hDB); send(8'h00); send(8'h0A); send(8'h00); spi_end(1);

    // R9: page program and page write data bytes
    wb_q.push_back(8'hA1); wb_q.push_back(8'hB2); wb_q.push_back(8'hC3);
    cmd_q.push_back({3'd5, 19'h00310});
    spi_start(0); send(8'h02); send(8'h00); send(8'h03); send(8'h10);
    send(8'hA1); send(8'hB2); send(8'hC3); spi_end(0);
    wb_q.push_back(8'h5A);
    cmd_q.push_back({3'd6, 19'h7FF00});
    spi_start(1); send(8'h0A); send(8'h07); send(8'hFF); send(8'h00); send(8'h5A); spi_end(1);

    // R10: off-boundary and short commands are dropped
    c0 = cmd_seen;
    spi_start(0); send(8'h06);
    begin logic [7:0] r; logic o; spi_bits(8'h05, 3, r, o); end
    spi_end(0);
    spi_start(0); send(8'hDB); send(8'h00); spi_end(0);
    spi_start(0); send(8'h02); send(8'h00); send(8'h01); send(8'h00); spi_end(0);
    check(cmd_seen == c0, "R10 no command", cmd_seen, c0);

    // R11: power-down gates everything but exit
    spi_start(0); send(8'hB9); spi_end(0);
    spi_start(0); send(8'h05); quiet_check("R11 status in power-down", 2); spi_end(0);
    c0 = cmd_seen;
    spi_start(0); send(8'h06); spi_end(0);
    check(cmd_seen == c0, "R11 command in power-down", cmd_seen, c0);
    spi_start(0); send(8'hAB); spi_end(0);
    rx_q.push_back(8'h02);
    spi_start(0); send(8'h05); read_check("R11 status after exit", 1); spi_end(0);

    tick(10);
    check(cmd_q.size() == 0, "R8 pending commands", cmd_q.size(), 0);
    check(wb_q.size() == 0, "R9 pending data bytes", wb_q.size(), 0);
    check(miso_oe == 1'b0, "R1 final idle", {31'd0, miso_oe}, 32'd0);
    finish_run();
  end
endmodule